// File: doc/BRIEF.md
# NOR Flash Command Interface Controller

This block is a clock-synchronous model of the command decoder and status logic in front of a 16-bit NOR flash array. A host drives chip-enable, output-enable and write-enable strobes, an address and a data word. All of these are sampled on the system clock. Each bus write carries a command code in its low byte. The block keeps a read mode that decides whether reads return array words or the status register. It runs a two-write program sequence that is timed by a cycle counter. Error flags in the status register stay set until software explicitly clears them.

A program operation can only turn 1 bits into 0 bits in the stored word. It is refused when the programming voltage is reported bad or when the target block is locked. If the voltage drops before the operation completes, a program failure is reported. Status reads freeze the status byte at the start of each read strobe. A host that polls for completion must therefore drop and reassert the strobe.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: After reset, the read mode is array, the status byte is 0x80, and every array word is 0xFFFF.
- R2: A write of 0x70 sets the read mode to status. The mode then holds through any number of reads. A write of an unknown code (any code other than 0x70, 0xFF, 0x50, 0x40) leaves the mode unchanged.
- R3: A write of 0xFF sets the read mode to array. A read then returns the stored word at the read address.
- R4: A write of 0x40 arms a program and sets the read mode to status. The next write supplies the address and data and starts the operation. Status bit 7 is 0 for exactly PROG_CYC cycles and then returns to 1.
- R5: A completed program stores the old word ANDed with the written data.
- R6: If vpp_ok is low at the second write, status bit 3 is set and the array is not changed. Bit 7 is already 1 at the next read.
- R7: If the target block (block index = upper address bits, so addr[5:4] by default) is locked, status bit 1 is set and the array is not changed.
- R8: If vpp_ok is low when the program counter expires, status bit 4 is set and the array word is unchanged.
- R9: Status bits 1, 3, 4 and 5 accumulate across operations. Only a write of 0x50 clears them.
- R10: During a status read, dout[7:0] carries the status byte and dout[15:8] is 0x00.
- R11: The status byte is captured on the first clock of a read strobe (ce_n and oe_n both low). It is held unchanged for as long as the strobe stays asserted.
- R12: While a program runs, a write of 0x70 is accepted and writes of 0xB0 and 0xD0 are accepted without effect. Every other write is ignored, including 0xFF and 0x40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; a write is taken on the first clock it is seen low with ce_n low |
| addr | input | ADDR_W | Word address |
| din | input | 16 | Write data; command code in bits 7:0 |
| vpp_ok | input | 1 | Programming voltage within range |
| blk_lock | input | NUM_BLK | Per-block lock flags |
| dout | output | 16 | Read data; zero when no read strobe is active |

## Verification
Several properties are checked on every cycle. The error flags can never fall except on a clear command, and an array commit never happens with the voltage bad. The upper byte of a status read is always zero, and the status byte stays stable while a strobe is held. A program never lasts longer than its configured length, and the read mode is status for the whole operation. Other behaviours need the bench's scenarios to show them: the AND result stored in the array, the accumulation of several distinct errors, the refusal of 0xFF and 0x40 during an operation, and the completion that becomes visible only after a fresh strobe.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_BUSY  = 2'd2
  } nfsm_e;

  localparam logic [7:0] CMD_RD_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_RD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_CLR_STATUS = 8'h50;
  localparam logic [7:0] CMD_PROG_SETUP = 8'h40;
  localparam logic [7:0] CMD_SUSPEND    = 8'hB0;
  localparam logic [7:0] CMD_RESUME     = 8'hD0;

  // index into the stored error vector
  localparam int E_LOCK  = 0;  // status bit 1
  localparam int E_VPP   = 1;  // status bit 3
  localparam int E_PFAIL = 2;  // status bit 4
  localparam int E_ERASE = 3;  // status bit 5

  localparam logic [7:0] SR_STICKY_MASK = 8'h3A;

endpackage

// File: rtl/nor_bus_sync.sv
module nor_bus_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic wr_stb,
  output logic rd_act,
  output logic rd_first
);

  logic we_q, we_n_d;
  logic rd_q, rd_d;

  always_comb begin
    rd_act   = ~ce_n & ~oe_n;
    wr_stb   = ~ce_n & ~we_n & we_q;
    rd_first = rd_act & ~rd_q;
    we_n_d   = we_n;
    rd_d     = rd_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b1;
      rd_q <= 1'b0;
    end else begin
      we_q <= we_n_d;
      rd_q <= rd_d;
    end
  end

endmodule

// File: rtl/nor_array.sv
module nor_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] cell_n;

  always_comb begin
    rdata  = mem_q[raddr];
    cell_n = mem_q[waddr] & wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (we) begin
      mem_q[waddr] <= cell_n;
    end
  end

endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16,
  parameter int NUM_BLK  = 4,
  parameter int PROG_CYC = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_stb,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               vpp_ok,
  input  logic [NUM_BLK-1:0] blk_lock,
  output logic               busy,
  output logic               mode_sts,
  output logic [7:0]         sr,
  output logic               clr_pulse,
  output logic               arr_we,
  output logic [ADDR_W-1:0]  arr_waddr,
  output logic [DATA_W-1:0]  arr_wdata
);

  localparam int BLK_W = $clog2(NUM_BLK);
  localparam int CNT_W = $clog2(PROG_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PROG_CYC - 1);

  nfsm_e             st_q, st_n;
  logic              mode_q, mode_n;
  logic [3:0]        err_q, err_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [ADDR_W-1:0] pa_q, pa_n;
  logic [DATA_W-1:0] pd_q, pd_n;
  logic [BLK_W-1:0]  blk_sel;
  logic [7:0]        cmd;

  always_comb begin
    blk_sel   = wr_addr[ADDR_W-1 -: BLK_W];
    cmd       = wr_data[7:0];
    st_n      = st_q;
    mode_n    = mode_q;
    err_n     = err_q;
    cnt_n     = cnt_q;
    pa_n      = pa_q;
    pd_n      = pd_q;
    clr_pulse = 1'b0;
    arr_we    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (wr_stb) begin
          case (cmd)
            CMD_RD_STATUS:  mode_n = 1'b1;
            CMD_RD_ARRAY:   mode_n = 1'b0;
            CMD_CLR_STATUS: begin
              err_n     = '0;
              clr_pulse = 1'b1;
            end
            CMD_PROG_SETUP: begin
              st_n   = ST_ARMED;
              mode_n = 1'b1;
            end
            default: ;
          endcase
        end
      end
      ST_ARMED: begin
        if (wr_stb) begin
          pa_n = wr_addr;
          pd_n = wr_data;
          if (!vpp_ok) begin
            err_n[E_VPP] = 1'b1;
            st_n         = ST_IDLE;
          end else if (blk_lock[blk_sel]) begin
            err_n[E_LOCK] = 1'b1;
            st_n          = ST_IDLE;
          end else begin
            st_n  = ST_BUSY;
            cnt_n = CNT_LOAD;
          end
        end
      end
      ST_BUSY: begin
        if (wr_stb) begin
          case (cmd)
            CMD_RD_STATUS:           mode_n = 1'b1;
            CMD_SUSPEND, CMD_RESUME: ;
            default: ;
          endcase
        end
        if (cnt_q == '0) begin
          if (vpp_ok) arr_we = 1'b1;
          else        err_n[E_PFAIL] = 1'b1;
          st_n = ST_IDLE;
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mode_q <= 1'b0;
      err_q  <= '0;
      cnt_q  <= '0;
      pa_q   <= '0;
      pd_q   <= '0;
    end else begin
      st_q   <= st_n;
      mode_q <= mode_n;
      err_q  <= err_n;
      cnt_q  <= cnt_n;
      pa_q   <= pa_n;
      pd_q   <= pd_n;
    end
  end

  always_comb begin
    busy      = (st_q == ST_BUSY);
    mode_sts  = mode_q;
    sr        = {~busy, 1'b0, err_q[E_ERASE], err_q[E_PFAIL], err_q[E_VPP],
                 1'b0, err_q[E_LOCK], 1'b0};
    arr_waddr = pa_q;
    arr_wdata = pd_q;
  end

endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int NUM_BLK  = 4,
  parameter int PROG_CYC = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce_n,
  input  logic               oe_n,
  input  logic               we_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [15:0]        din,
  input  logic               vpp_ok,
  input  logic [NUM_BLK-1:0] blk_lock,
  output logic [15:0]        dout
);

  localparam int DATA_W = 16;

  logic              wr_stb, rd_act, rd_first;
  logic              busy, mode_sts, clr_pulse, arr_we;
  logic [7:0]        sr, sr_hold_q, sr_hold_n, sr_view;
  logic [ADDR_W-1:0] arr_waddr;
  logic [DATA_W-1:0] arr_wdata, arr_rdata;

  nor_bus_sync u_bus (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .wr_stb   (wr_stb),
    .rd_act   (rd_act),
    .rd_first (rd_first)
  );

  nor_cmd_fsm #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_BLK  (NUM_BLK),
    .PROG_CYC (PROG_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb),
    .wr_addr   (addr),
    .wr_data   (din),
    .vpp_ok    (vpp_ok),
    .blk_lock  (blk_lock),
    .busy      (busy),
    .mode_sts  (mode_sts),
    .sr        (sr),
    .clr_pulse (clr_pulse),
    .arr_we    (arr_we),
    .arr_waddr (arr_waddr),
    .arr_wdata (arr_wdata)
  );

  nor_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_arr (
    .clk   (clk),
    .rst_n (rst_n),
    .raddr (addr),
    .rdata (arr_rdata),
    .we    (arr_we),
    .waddr (arr_waddr),
    .wdata (arr_wdata)
  );

  // freeze status at the first clock of each read strobe
  always_comb begin
    sr_hold_n = rd_first ? sr : sr_hold_q;
    sr_view   = rd_first ? sr : sr_hold_q;
    if (!rd_act)       dout = '0;
    else if (mode_sts) dout = {{(DATA_W-8){1'b0}}, sr_view};
    else               dout = arr_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_hold_q <= 8'h80;
    else        sr_hold_q <= sr_hold_n;
  end

endmodule

// File: rtl/nor_cmd_ctrl_chk.sv
module nor_cmd_ctrl_chk #(
  parameter int PROG_CYC = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ce_n,
  input logic        oe_n,
  input logic        vpp_ok,
  input logic [15:0] dout,
  input logic        busy,
  input logic        mode_sts,
  input logic        clr_pulse,
  input logic        arr_we,
  input logic [7:0]  sr
);

  localparam int BC_W = $clog2(PROG_CYC + 2);
  localparam logic [BC_W-1:0] BC_MAX = BC_W'(PROG_CYC + 1);

  logic [BC_W-1:0] bcnt_q;
  logic            rd_on;

  assign rd_on = ~ce_n & ~oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              bcnt_q <= '0;
    else if (!busy)          bcnt_q <= '0;
    else if (bcnt_q != BC_MAX) bcnt_q <= bcnt_q + 1'b1;
  end

  // R9: error flags only fall on a clear command
  p_sticky_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_pulse |=> ((sr & 8'h3A) & $past(sr & 8'h3A)) == $past(sr & 8'h3A));

  // R8: no commit to the array with the voltage bad
  p_commit_vpp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> vpp_ok);

  // R10: upper byte zero during status reads
  p_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_on && mode_sts) |-> dout[15:8] == 8'h00);

  // R11: status byte held while the strobe stays asserted
  p_sts_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_on && $past(rd_on) && mode_sts && $past(mode_sts)) |-> $stable(dout[7:0]));

  // R4: an operation never exceeds its configured length
  p_prog_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bcnt_q < BC_W'(PROG_CYC));

  // R12: read mode is status throughout an operation
  p_busy_status_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> mode_sts);

endmodule

bind nor_cmd_ctrl nor_cmd_ctrl_chk #(.PROG_CYC(PROG_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce_n      (ce_n),
  .oe_n      (oe_n),
  .vpp_ok    (vpp_ok),
  .dout      (dout),
  .busy      (busy),
  .mode_sts  (mode_sts),
  .clr_pulse (clr_pulse),
  .arr_we    (arr_we),
  .sr        (sr)
);

// File: tb/sim_nor_cmd_ctrl.sv
module sim_nor_cmd_ctrl;

  localparam int ADDR_W   = 6;
  localparam int NUM_BLK  = 4;
  localparam int PROG_CYC = 16;

  logic               clk, rst_n, ce_n, oe_n, we_n, vpp_ok;
  logic [ADDR_W-1:0]  addr;
  logic [15:0]        din, dout;
  logic [NUM_BLK-1:0] blk_lock;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] rv;

  nor_cmd_ctrl #(.ADDR_W(ADDR_W), .NUM_BLK(NUM_BLK), .PROG_CYC(PROG_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .vpp_ok(vpp_ok), .blk_lock(blk_lock), .dout(dout)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // op: 0 command write, 1 read and compare, 2 data write then wait out the program
  // fields: op[43:42] req[41:38] addr[37:32] data[31:16] exp[15:0]
  localparam int NV = 16;
  localparam logic [43:0] VEC [NV] = '{
    {2'd0, 4'd3,  6'h00, 16'h00FF, 16'h0000},
    {2'd1, 4'd3,  6'h00, 16'h0000, 16'hFFFF},  // R3 erased word
    {2'd0, 4'd2,  6'h00, 16'h0070, 16'h0000},
    {2'd1, 4'd2,  6'h00, 16'h0000, 16'h0080},  // R2 status mode
    {2'd0, 4'd2,  6'h00, 16'h0012, 16'h0000},  // unknown code
    {2'd1, 4'd2,  6'h11, 16'h0000, 16'h0080},  // R2 mode kept
    {2'd0, 4'd4,  6'h00, 16'h0040, 16'h0000},
    {2'd2, 4'd4,  6'h03, 16'hA5F0, 16'h0000},
    {2'd1, 4'd4,  6'h03, 16'h0000, 16'h0080},  // R4 done, status mode
    {2'd0, 4'd3,  6'h00, 16'h00FF, 16'h0000},
    {2'd1, 4'd5,  6'h03, 16'h0000, 16'hA5F0},  // R5 first program
    {2'd0, 4'd5,  6'h00, 16'h0040, 16'h0000},
    {2'd2, 4'd5,  6'h03, 16'h0F0F, 16'h0000},
    {2'd0, 4'd3,  6'h00, 16'h00FF, 16'h0000},
    {2'd1, 4'd5,  6'h03, 16'h0000, 16'h0500},  // R5 AND result
    {2'd1, 4'd3,  6'h04, 16'h0000, 16'hFFFF}   // R3 neighbour intact
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%04h expected=%04h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [15:0] q);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    q = dout;
    oe_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_prog();
    repeat (PROG_CYC + 4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    addr = '0; din = '0; vpp_ok = 1'b1; blk_lock = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_rd(6'h2A, rv); check("R1 array mode after reset", rv, 16'hFFFF);
    check("R1 idle output", dout, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      logic [43:0] v;
      string tg;
      v = VEC[i];
      tg = $sformatf("R%0d vector %0d", v[41:38], i);
      case (v[43:42])
        2'd0: bus_wr(v[37:32], v[31:16]);
        2'd2: begin bus_wr(v[37:32], v[31:16]); wait_prog(); end
        default: begin bus_rd(v[37:32], rv); check(tg, rv, v[15:0]); end
      endcase
    end

    // R6 voltage bad at second write
    vpp_ok = 1'b0;
    bus_wr(6'h05, 16'h0040); bus_wr(6'h05, 16'h0000);
    bus_rd(6'h05, rv); check("R6 vpp error, ready at once", rv, 16'h0088);
    vpp_ok = 1'b1;
    bus_wr(6'h00, 16'h0050); bus_wr(6'h00, 16'h0070);
    bus_rd(6'h00, rv); check("R9 clear", rv, 16'h0080);

    // R7 locked block, then R9 accumulate with a voltage error
    blk_lock = 4'b0100;
    bus_wr(6'h21, 16'h0040); bus_wr(6'h21, 16'h0000);
    bus_rd(6'h21, rv); check("R7 lock error", rv, 16'h0082);
    vpp_ok = 1'b0;
    bus_wr(6'h06, 16'h0040); bus_wr(6'h06, 16'h0000);
    bus_rd(6'h06, rv); check("R9 accumulate", rv, 16'h008A);
    vpp_ok = 1'b1; blk_lock = '0;
    bus_wr(6'h00, 16'h00FF);
    bus_rd(6'h21, rv); check("R7 locked word unchanged", rv, 16'hFFFF);
    bus_rd(6'h06, rv); check("R6 word unchanged", rv, 16'hFFFF);
    bus_wr(6'h00, 16'h0050); bus_wr(6'h00, 16'h0070);
    bus_rd(6'h00, rv); check("R9 cleared after series", rv, 16'h0080);

    // R8 voltage lost during the operation
    bus_wr(6'h07, 16'h0040); bus_wr(6'h07, 16'h0000);
    @(negedge clk); vpp_ok = 1'b0;
    wait_prog();
    vpp_ok = 1'b1;
    bus_rd(6'h07, rv); check("R8 program fail flag", rv, 16'h0090);
    bus_wr(6'h00, 16'h00FF);
    bus_rd(6'h07, rv); check("R8 word unchanged", rv, 16'hFFFF);
    bus_wr(6'h00, 16'h0050);

    // R11 frozen status across completion, R4 busy visible
    bus_wr(6'h09, 16'h0040); bus_wr(6'h09, 16'h00FF);
    @(negedge clk); addr = 6'h09; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); check("R4 busy during program", dout, 16'h0000);
    wait_prog();
    check("R11 held across completion", dout, 16'h0000);
    oe_n = 1'b1; ce_n = 1'b1;
    bus_rd(6'h09, rv); check("R11 fresh strobe sees done", rv, 16'h0080);

    // R12 writes during an operation
    bus_wr(6'h0A, 16'h0040); bus_wr(6'h0A, 16'h1234);
    bus_wr(6'h0A, 16'h00FF);
    bus_wr(6'h0A, 16'h0040);
    bus_wr(6'h0A, 16'h00B0);
    bus_rd(6'h0A, rv); check("R12 array cmd ignored while busy", rv, 16'h0000);
    wait_prog();
    bus_rd(6'h0A, rv); check("R12 mode still status", rv, 16'h0080);
    bus_wr(6'h0B, 16'h0000);
    bus_wr(6'h00, 16'h00FF);
    bus_rd(6'h0A, rv); check("R12 program completed", rv, 16'h1234);
    bus_rd(6'h0B, rv); check("R12 setup not armed", rv, 16'hFFFF);
    bus_rd(6'h09, rv); check("R5 00FF programmed", rv, 16'h00FF);

    finish_run();
  end

endmodule